// File: doc/BRIEF.md
# Virtual Framebuffer Address Translator

This block maps read addresses from a virtual framebuffer space onto physical memory addresses. The virtual space holds several buffers. Each buffer has a physical base (its upper address bits) and a physical offset of its own. A shared per-line table decides which part of every display line is backed by memory. Each table entry has an enable bit, a window of valid 16-byte blocks given as a first and a last block number, and a line offset. Lines are packed end to end in memory, so only the visible part of a line (for example on a round display) takes up storage.

A request carries a virtual address, which is split from the top down into a buffer select, a line index, a block index and a byte offset. The answer comes one clock later. It gives either a physical address with the mapped bit set, or the mapped bit cleared together with a programmable default data word. An unmapped access generates no physical address. Requests and responses use a valid/ready handshake. A new request is accepted while no response is pending, or while the pending one is being taken in the same cycle. A response that is not taken stays unchanged on the outputs. The line table is written through a plain one-entry-per-cycle write port. Per-buffer overflow flags, their write-1-to-clear inputs and the interrupt enables are plain control pins.

Top module: `vfb_xlate`

## Requirements
- R1: A mapped access on buffer b returns `rsp_paddr = {base_b, S[22:0]}`, where S is the 24-bit sum of `{pbo_b,4'b0}`, `{line_offset,4'b0}`, `block*16` and the byte offset. The virtual address is laid out, from the top down, as `{buffer, line, block[7:0], byte[3:0]}`.
- R2: An access is unmapped when its line's enable bit is 0, when its block is below the line's first valid block, or when its block is above the line's last valid block. Such a response has `rsp_mapped=0`, `rsp_paddr=0` and `rsp_data=default_word`. A mapped response has `rsp_data=0`.
- R3: With `mode192=1`, block numbers 192 to 255 are unmapped whatever the table says. With `mode192=0`, all 256 block numbers follow the table.
- R4: When a mapped access's sum S has bit 23 set, the overflow flag of its buffer goes to 1, visible with the response. The address still uses only S[22:0].
- R5: A 1 on `flag_clr[i]` for one cycle clears `ovf_flags[i]` at the next edge. A 0 leaves the flag as it is. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R6: `irq` is 1 exactly when some flag `ovf_flags[i]` and its enable `irq_en[i]` are both 1.
- R7: A response appears one cycle after a request is accepted. `req_ready = !rsp_valid || rsp_ready`. While `rsp_valid=1` and `rsp_ready=0`, the response outputs hold still.
- R8: A table write to the line that a translation reads in the same cycle is not seen by that translation. It is seen by every later one.
- R9: After reset, `rsp_valid=0`, all overflow flags are 0 and every table line is disabled.
- R10: Buffer configuration word b sits at `buf_cfg[32*b+31:32*b]`. Its bits 31:23 are the physical base and bits 22:4 the physical buffer offset; bits 3:0 are ignored. The buffer-select field of the address chooses the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode192 | input | 1 | 1 = 192 blocks per line, 0 = 256 |
| default_word | input | 32 | Data returned for unmapped accesses |
| buf_cfg | input | 32*NBUF | Per-buffer base and offset words |
| irq_en | input | NBUF | Per-buffer interrupt enable |
| flag_clr | input | NBUF | Write-1-to-clear pulses for the overflow flags |
| ovf_flags | output | NBUF | Sticky per-buffer overflow flags |
| irq | output | 1 | OR of the enabled flags |
| tbl_we | input | 1 | Line table write strobe |
| tbl_idx | input | LINE_W | Line number to write |
| tbl_enable | input | 1 | Line enable value to write |
| tbl_first | input | 8 | First valid block value to write |
| tbl_last | input | 8 | Last valid block value to write |
| tbl_loff | input | 18 | Line offset value to write |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Virtual address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address (0 when unmapped) |
| rsp_mapped | output | 1 | Location backed by memory |
| rsp_data | output | 32 | Default word when unmapped, else 0 |

## Verification
On every cycle, the assertions check the handshake: responses hold while stalled and an accepted request always yields a response. They also check that unmapped responses carry a zero address, that the narrow mode blocks the upper block numbers, that flags set, clear and stick as specified, and that a table write is visible the next cycle. The actual address arithmetic, the carry into the base field, the window comparisons against the table and the same-cycle write ordering can be shown only by the bench. It sweeps every buffer, line and block of a small table in both line-width modes and compares each result with an independently computed value.

// File: rtl/vfb_pkg.sv
package vfb_pkg;
  localparam int BLK_W    = 8;
  localparam int BYTE_W   = 4;
  localparam int BASE_W   = 9;
  localparam int PBO_W    = 19;
  localparam int LOFF_W   = 18;
  localparam int OFS_W    = 23;
  localparam int PADDR_W  = 32;
  localparam int CFG_W    = 32;
  localparam int DATA_W   = 32;
  localparam int BASE_LSB = 23;
  localparam int PBO_LSB  = 4;
  localparam int NARROW_LIMIT = 192;

  typedef struct packed {
    logic [BLK_W-1:0]  first;
    logic [BLK_W-1:0]  last;
    logic [LOFF_W-1:0] loff;
  } line_body_t;

  typedef struct packed {
    logic       en;
    line_body_t body;
  } line_ent_t;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [PBO_W-1:0]  pbo;
  } buf_cfg_t;
endpackage

// File: rtl/vfb_line_table.sv
module vfb_line_table
  import vfb_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LINE_W-1:0] widx,
  input  line_ent_t         wdata,
  input  logic [LINE_W-1:0] ridx,
  output line_ent_t         rdata
);
  localparam int LINES = 1 << LINE_W;

  logic [LINES-1:0] en_q;
  line_body_t       body_q [LINES];

  // Only the enable bits need a reset; a disabled line ignores its body.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (we) en_q[widx] <= wdata.en;
  end

  always_ff @(posedge clk) begin
    if (we) body_q[widx] <= wdata.body;
  end

  // Read before write: a same-cycle write appears from the next cycle.
  always_comb begin
    rdata.en   = en_q[ridx];
    rdata.body = body_q[ridx];
  end

  p_write_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (en_q[$past(widx)] == $past(wdata.en)) &&
           (body_q[$past(widx)] == $past(wdata.body)));
endmodule

// File: rtl/vfb_xlate_calc.sv
module vfb_xlate_calc
  import vfb_pkg::*;
(
  input  logic               mode192,
  input  line_ent_t          ent,
  input  buf_cfg_t           cfg,
  input  logic [BLK_W-1:0]   blk,
  input  logic [BYTE_W-1:0]  byte_ofs,
  output logic               mapped,
  output logic [PADDR_W-1:0] paddr,
  output logic               carry
);
  localparam int SUM_W = OFS_W + 1;

  logic [SUM_W-1:0] sum;
  logic             in_window;
  logic             in_width;

  always_comb begin
    in_width  = !(mode192 && (blk >= BLK_W'(NARROW_LIMIT)));
    in_window = (blk >= ent.body.first) && (blk <= ent.body.last);
    mapped    = ent.en && in_window && in_width;
    sum = SUM_W'({cfg.pbo, {BYTE_W{1'b0}}})
        + SUM_W'({ent.body.loff, {BYTE_W{1'b0}}})
        + SUM_W'({blk, {BYTE_W{1'b0}}})
        + SUM_W'(byte_ofs);
    carry = mapped && sum[OFS_W];
    paddr = mapped ? {cfg.base, sum[OFS_W-1:0]} : '0;
  end
endmodule

// File: rtl/vfb_ovf_flags.sv
module vfb_ovf_flags #(
  parameter int NBUF = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] set,
  input  logic [NBUF-1:0] clr,
  input  logic [NBUF-1:0] en,
  output logic [NBUF-1:0] flags,
  output logic            irq
);
  logic [NBUF-1:0] flags_q;

  // Set dominates clear so that no overflow event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr) | set;
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & en);

  p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags_q & $past(set)) == $past(set)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((flags_q & $past(clr & ~set)) == '0));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_q) |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr)));
endmodule

// File: rtl/vfb_xlate.sv
module vfb_xlate
  import vfb_pkg::*;
#(
  parameter  int LINE_W = 10,
  parameter  int NBUF   = 4,
  localparam int BSEL_W = $clog2(NBUF),
  localparam int ADDR_W = BSEL_W + LINE_W + BLK_W + BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode192,
  input  logic [DATA_W-1:0]    default_word,
  input  logic [NBUF*CFG_W-1:0] buf_cfg,
  input  logic [NBUF-1:0]      irq_en,
  input  logic [NBUF-1:0]      flag_clr,
  output logic [NBUF-1:0]      ovf_flags,
  output logic                 irq,
  input  logic                 tbl_we,
  input  logic [LINE_W-1:0]    tbl_idx,
  input  logic                 tbl_enable,
  input  logic [BLK_W-1:0]     tbl_first,
  input  logic [BLK_W-1:0]     tbl_last,
  input  logic [LOFF_W-1:0]    tbl_loff,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [PADDR_W-1:0]   rsp_paddr,
  output logic                 rsp_mapped,
  output logic [DATA_W-1:0]    rsp_data
);
  localparam int BYTE_LSB = 0;
  localparam int BLK_LSB  = BYTE_LSB + BYTE_W;
  localparam int LINE_LSB = BLK_LSB + BLK_W;
  localparam int BSEL_LSB = LINE_LSB + LINE_W;

  // Address fields
  logic [BSEL_W-1:0] bsel;
  logic [LINE_W-1:0] line_idx;
  logic [BLK_W-1:0]  blk;
  logic [BYTE_W-1:0] byte_ofs;

  assign bsel     = req_addr[BSEL_LSB +: BSEL_W];
  assign line_idx = req_addr[LINE_LSB +: LINE_W];
  assign blk      = req_addr[BLK_LSB  +: BLK_W];
  assign byte_ofs = req_addr[BYTE_LSB +: BYTE_W];

  // Per-buffer configuration unpacking
  buf_cfg_t        cfg_arr [NBUF];
  logic [NBUF-1:0] unused_cfg_nib;

  for (genvar g = 0; g < NBUF; g++) begin : g_cfg
    assign cfg_arr[g].base   = buf_cfg[g*CFG_W + BASE_LSB +: BASE_W];
    assign cfg_arr[g].pbo    = buf_cfg[g*CFG_W + PBO_LSB  +: PBO_W];
    assign unused_cfg_nib[g] = ^buf_cfg[g*CFG_W +: PBO_LSB];
  end

  buf_cfg_t sel_cfg;
  assign sel_cfg = cfg_arr[bsel];

  // Line table
  line_ent_t wr_ent;
  line_ent_t rd_ent;

  always_comb begin
    wr_ent.en         = tbl_enable;
    wr_ent.body.first = tbl_first;
    wr_ent.body.last  = tbl_last;
    wr_ent.body.loff  = tbl_loff;
  end

  vfb_line_table #(.LINE_W(LINE_W)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .widx  (tbl_idx),
    .wdata (wr_ent),
    .ridx  (line_idx),
    .rdata (rd_ent)
  );

  // Translation
  logic               c_mapped;
  logic [PADDR_W-1:0] c_paddr;
  logic               c_carry;

  vfb_xlate_calc u_calc (
    .mode192  (mode192),
    .ent      (rd_ent),
    .cfg      (sel_cfg),
    .blk      (blk),
    .byte_ofs (byte_ofs),
    .mapped   (c_mapped),
    .paddr    (c_paddr),
    .carry    (c_carry)
  );

  // Handshake and response register
  logic               accept;
  logic               rsp_valid_q;
  logic               mapped_q;
  logic [PADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0]  data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      mapped_q    <= 1'b0;
      paddr_q     <= '0;
      data_q      <= '0;
    end else if (req_ready) begin
      rsp_valid_q <= req_valid;
      if (req_valid) begin
        mapped_q <= c_mapped;
        paddr_q  <= c_paddr;
        data_q   <= c_mapped ? '0 : default_word;
      end
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_mapped = mapped_q;
  assign rsp_paddr  = paddr_q;
  assign rsp_data   = data_q;

  // Overflow flags
  logic [NBUF-1:0] ovf_set;
  assign ovf_set = (accept && c_carry) ? (NBUF'(1) << bsel) : '0;

  vfb_ovf_flags #(.NBUF(NBUF)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ovf_set),
    .clr   (flag_clr),
    .en    (irq_en),
    .flags (ovf_flags),
    .irq   (irq)
  );

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_paddr) &&
                                  $stable(rsp_mapped) && $stable(rsp_data));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_mapped) |-> (rsp_paddr == '0));

  p_mapped_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mapped) |-> (rsp_data == '0));

  p_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode192 && (blk >= BLK_W'(NARROW_LIMIT))) |=> !rsp_mapped);
endmodule

// File: tb/vfb_xlate_test.sv
`timescale 1ns/1ps
module vfb_xlate_test;
  localparam int LW = 3;
  localparam int NB = 4;
  localparam int AW = 2 + LW + 8 + 4;
  localparam int NL = 1 << LW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n, mode192, irq, tbl_we, tbl_enable;
  logic [31:0]    default_word;
  logic [NB*32-1:0] buf_cfg;
  logic [NB-1:0]  irq_en, flag_clr, ovf_flags;
  logic [LW-1:0]  tbl_idx;
  logic [7:0]     tbl_first, tbl_last;
  logic [17:0]    tbl_loff;
  logic           req_valid, req_ready, rsp_valid, rsp_ready, rsp_mapped;
  logic [AW-1:0]  req_addr;
  logic [31:0]    rsp_paddr, rsp_data;

  vfb_xlate #(.LINE_W(LW), .NBUF(NB)) uut (
    .clk(clk), .rst_n(rst_n), .mode192(mode192), .default_word(default_word),
    .buf_cfg(buf_cfg), .irq_en(irq_en), .flag_clr(flag_clr),
    .ovf_flags(ovf_flags), .irq(irq), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_enable(tbl_enable), .tbl_first(tbl_first), .tbl_last(tbl_last),
    .tbl_loff(tbl_loff), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_mapped(rsp_mapped), .rsp_data(rsp_data)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic        m_en    [NL];
  logic [7:0]  m_first [NL];
  logic [7:0]  m_last  [NL];
  logic [17:0] m_loff  [NL];
  logic [8:0]  c_base  [NB];
  logic [18:0] c_pbo   [NB];
  logic [NB-1:0] exp_flags;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int b, input int l, input int blk, input int byt);
    return {2'(b), 3'(l), 8'(blk), 4'(byt)};
  endfunction

  task automatic model(input int b, input int l, input int blk, input int byt, input logic md,
                       output logic mp, output logic [31:0] pa, output logic cy);
    logic [23:0] s;
    mp = m_en[l] && (blk >= int'(m_first[l])) && (blk <= int'(m_last[l])) && !(md && blk >= 192);
    s  = {1'b0, c_pbo[b], 4'b0} + {2'b0, m_loff[l], 4'b0} + 24'(blk * 16) + 24'(byt);
    cy = mp && s[23];
    pa = mp ? {c_base[b], s[22:0]} : 32'h0;
  endtask

  task automatic send(input logic [AW-1:0] a);
    req_addr  = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // One translation, checked against the model; flags checked too (R4)
  task automatic run_vec(input int b, input int l, input int blk, input int byt);
    logic mp, cy;
    logic [31:0] pa;
    string tag;
    model(b, l, blk, byt, mode192, mp, pa, cy);
    send(mk_addr(b, l, blk, byt));
    tag = (mode192 && blk >= 192) ? "R3" : (!mp ? "R2" : "R1 R10");
    check(tag, {rsp_valid, rsp_mapped, rsp_paddr, rsp_data},
          {1'b1, mp, pa, mp ? 32'h0 : default_word});
    if (cy) exp_flags[b] = 1'b1;
    check("R4", 128'(ovf_flags), 128'(exp_flags));
  endtask

  task automatic prog(input int l, input logic en, input logic [7:0] f, input logic [7:0] la,
                      input logic [17:0] lo);
    tbl_idx = LW'(l); tbl_enable = en; tbl_first = f; tbl_last = la; tbl_loff = lo;
    tbl_we = 1'b1;
    @(negedge clk);
    tbl_we = 1'b0;
    m_en[l] = en; m_first[l] = f; m_last[l] = la; m_loff[l] = lo;
  endtask

  task automatic clear_flags();
    flag_clr = '1;
    @(negedge clk);
    flag_clr = '0;
    exp_flags = '0;
    check("R5", 128'(ovf_flags), 128'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa_a, pa_b, pa_old;
    logic mp, cy;
    rst_n = 0; mode192 = 0; default_word = 32'hFACE_0256; buf_cfg = '0;
    irq_en = '0; flag_clr = '0; tbl_we = 0; tbl_idx = '0; tbl_enable = 0;
    tbl_first = '0; tbl_last = '0; tbl_loff = '0; req_valid = 0; req_addr = '0;
    rsp_ready = 1; exp_flags = '0;
    for (int l = 0; l < NL; l++) begin
      m_en[l] = 0; m_first[l] = 0; m_last[l] = 0; m_loff[l] = 0;
    end
    c_base[0] = 9'h001; c_pbo[0] = 19'h00000;
    c_base[1] = 9'h0A5; c_pbo[1] = 19'h12345;
    c_base[2] = 9'h1FF; c_pbo[2] = 19'h40000;
    c_base[3] = 9'h100; c_pbo[3] = 19'h7FFF0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: reset state
    check("R9", {rsp_valid, req_ready, irq, 4'(ovf_flags)}, {1'b0, 1'b1, 1'b0, 4'h0});
    for (int b = 0; b < NB; b++)  // low nibble is filler and must be ignored (R10)
      buf_cfg[b*32 +: 32] = {c_base[b], c_pbo[b], 4'h5};
    run_vec(0, 0, 10, 3);  // R9: every line disabled after reset

    for (int l = 0; l < NL; l++)
      prog(l, l != 5, 8'(l * 13), (l == 6) ? 8'd3 : 8'(255 - l * 9),
           18'(l * 32'h8F31 + 32'h123));

    // Full sweep in both line-width modes (R1, R2, R3, R4, R10)
    for (int md = 0; md < 2; md++) begin
      mode192 = md[0];
      default_word = md[0] ? 32'hC0DE_0192 : 32'hFACE_0256;
      clear_flags();
      for (int b = 0; b < NB; b++)
        for (int l = 0; l < NL; l++)
          for (int blk = 0; blk < 256; blk++)
            run_vec(b, l, blk, (blk ^ l) & 15);
    end

    // R5: write-1-to-clear, zeros ignored, set beats clear
    mode192 = 0;
    clear_flags();
    run_vec(3, 7, 100, 0);
    check("R4", 128'(ovf_flags), 128'(4'b1000));
    flag_clr = 4'b0111;
    @(negedge clk);
    flag_clr = 4'b0000;
    check("R5", 128'(ovf_flags), 128'(4'b1000));
    flag_clr = 4'b1000;
    @(negedge clk);
    flag_clr = 4'b0000;
    check("R5", 128'(ovf_flags), 128'(4'b0000));
    flag_clr = 4'b1000;
    send(mk_addr(3, 7, 100, 0));
    flag_clr = 4'b0000;
    check("R5", 128'(ovf_flags), 128'(4'b1000));

    // R6: interrupt is the OR of enabled flags
    irq_en = 4'b0111;
    #1 check("R6", 128'(irq), 128'(0));
    irq_en = 4'b1000;
    #1 check("R6", 128'(irq), 128'(1));
    @(negedge clk);
    clear_flags();
    check("R6", 128'(irq), 128'(0));
    irq_en = '0;

    // R7: back-pressure
    model(0, 0, 10, 3, 1'b0, mp, pa_a, cy);
    model(0, 0, 20, 7, 1'b0, mp, pa_b, cy);
    rsp_ready = 0;
    send(mk_addr(0, 0, 10, 3));
    check("R7", {rsp_valid, req_ready, rsp_paddr}, {1'b1, 1'b0, pa_a});
    req_addr = mk_addr(0, 0, 20, 7);
    req_valid = 1;
    @(negedge clk);
    check("R7", {rsp_valid, req_ready, rsp_paddr}, {1'b1, 1'b0, pa_a});
    @(negedge clk);
    check("R7", {rsp_valid, rsp_paddr}, {1'b1, pa_a});
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R7", {rsp_valid, rsp_paddr}, {1'b1, pa_b});
    @(negedge clk);
    check("R7", 128'(rsp_valid), 128'(0));

    // R8: same-cycle table write is seen only from the next cycle
    model(0, 2, 100, 1, 1'b0, mp, pa_old, cy);
    tbl_idx = 3'd2; tbl_enable = 0; tbl_first = 8'd0; tbl_last = 8'd255; tbl_loff = '0;
    tbl_we = 1;
    send(mk_addr(0, 2, 100, 1));
    tbl_we = 0;
    m_en[2] = 0; m_first[2] = 0; m_last[2] = 255; m_loff[2] = 0;
    check("R8", {rsp_mapped, rsp_paddr}, {1'b1, pa_old});
    send(mk_addr(0, 2, 100, 1));
    check("R8", {rsp_mapped, rsp_data}, {1'b0, default_word});
    prog(2, 1'b1, 8'd100, 8'd100, 18'h0);
    run_vec(0, 2, 100, 1);
    run_vec(0, 2, 101, 1);
    run_vec(0, 2, 99, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule